// File: doc/BRIEF.md
# Command-Addressed I2C Clock Register Target

This block is the serial front end of a real-time-clock register file. It listens on an open-drain two-wire bus as a target. The register to be accessed is not chosen by a pointer byte. Instead, three command bits inside the seven-bit address choose it. The upper four address bits carry a fixed device code, and the address byte itself travels most significant bit first. Every data byte after it, in either direction, travels least significant bit first.

The block holds three kinds of storage:
- a control/status byte with power-on and low-battery flags, a 24-hour select and a self-clearing reset command;
- a second status byte with a test-mode flag;
- a seven-byte BCD time block that a burst access walks through automatically.

The time block and the mode bits are presented in parallel to the timekeeping logic that sits next to this block. The low-battery condition comes in as a level from outside.

Top module: `rtc_i2c_target`

## Requirements
- R1: An address byte whose bits 7:4 equal 4'b0110 is acknowledged, whatever its command bits 3:1 and read/write bit 0 (1 = read). Any other address is not acknowledged, and the target leaves SDA released until the next START.
- R2: Command 0 selects the control/status byte, command 1 selects the second status byte and command 2 selects the time block. Commands 3 to 7 have no storage: their data bytes are not acknowledged on write and read as 8'hFF.
- R3: The address byte is shifted in MSB first. Every data byte is received and transmitted LSB first. The target changes its SDA drive only while SCL is low, except that it releases SDA on START or STOP.
- R4: The time block holds 7 bytes at indices 0 to 6: year, month, day, weekday, hour, minute, second. Each byte accepted in a burst advances the index by one. Byte k of the block appears on time_o[8k+7:8k].
- R5: The hour byte (index 4) keeps only its low 6 bits and the weekday byte (index 3) keeps only its low 3 bits. The upper bits of both always read as 0.
- R6: A write byte whose index is at or beyond the selected register's length is not acknowledged and not stored. A read at such an index returns 8'hFF. Every stored byte is acknowledged.
- R7: A START or a repeated START sets the byte index back to 0.
- R8: Layout of the control/status byte:
  - bit 7 is the power-on flag, which is set by rst_n and reads 1 after reset;
  - bit 6 is the low-battery flag, which is set while batt_low_i is 1 and stays set afterwards;
  - bit 1 is the 24-hour select, which can be read and written and drives hour24_o;
  - bit 0 and bits 5:2 read as 0.
- R9: Writing the control/status byte with bit 0 = 1 clears the power-on flag, the low-battery flag and all time bytes, and still loads bit 1 into the 24-hour select. The power-on flag is never cleared any other way.
- R10: Bit 7 of the second status byte is a test-mode flag that can be read and written and drives test_mode_o. It resets to 0, and bits 6:0 read as 0.
- R11: During a read, the target releases SDA for the controller's acknowledge bit. A controller NACK ends the read, and the target then stays released until the next START. A STOP always releases SDA.
- R12: After reset: sda_oe = 0, time_o = 0, hour24_o = 0 and test_mode_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset; sets the power-on flag |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_o | output | 1 | Data output value, always 0 (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| batt_low_i | input | 1 | Low-battery level from the supply monitor |
| time_o | output | 56 | Time block, byte k on bits 8k+7:8k |
| hour24_o | output | 1 | 24-hour mode select |
| test_mode_o | output | 1 | Test-mode flag |

## Verification
The assertions assume that the controller obeys bus timing:
- SDA changes only while SCL is low, apart from START and STOP conditions;
- SCL stays in each level for several system clocks, long enough for the synchronizer;
- no START or STOP is made while the target is pulling SDA low.

The bench's bus tasks keep this by holding each SCL phase for eight clocks and changing SDA only in the middle of the low phase. Bus contention is modelled as a wired AND. Random burst lengths run past the end of the time block, so the out-of-range path is stressed together with normal traffic.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

   localparam logic [2:0] CMD_STAT1 = 3'd0;
   localparam logic [2:0] CMD_STAT2 = 3'd1;
   localparam logic [2:0] CMD_TIME  = 3'd2;

   localparam int IDX_WEEKDAY = 3;
   localparam int IDX_HOUR    = 4;

   typedef enum logic [2:0] {
      LK_IDLE, LK_ADDR, LK_AACK, LK_WR, LK_WACK, LK_RD, LK_RACK
   } link_state_e;

   // number of bytes behind a command
   function automatic int reg_len(input logic [2:0] cmd, input int tbytes);
      case (cmd)
         CMD_STAT1, CMD_STAT2: reg_len = 1;
         CMD_TIME:             reg_len = tbytes;
         default:              reg_len = 0;
      endcase
   endfunction

   // bits kept per time byte
   function automatic logic [7:0] time_mask(input int idx);
      if (idx == IDX_WEEKDAY)   time_mask = 8'h07;
      else if (idx == IDX_HOUR) time_mask = 8'h3F;
      else                      time_mask = 8'hFF;
   endfunction

endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-2:0], d[g]};
      end
      assign q[g] = pipe[STAGES-1];
   end
endmodule

// File: rtl/rtc_i2c_link.sv
module rtc_i2c_link
   import rtc_i2c_pkg::*;
#(
   parameter logic [3:0] DEV_CODE   = 4'b0110,
   parameter int         TIME_BYTES = 7,
   localparam int        IDX_W      = $clog2(TIME_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl,
   input  logic             sda,
   input  logic [7:0]       rd_data,
   output logic             sda_oe,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic [2:0]       acc_cmd,
   output logic [IDX_W-1:0] acc_idx,
   output logic             start_det,
   output logic             stop_det
);
   link_state_e      st;
   logic             scl_q, sda_q, rw, nack;
   logic [3:0]       cnt;
   logic [7:0]       sh, tx;
   logic             rise, fall, in_range;

   assign rise      = scl & ~scl_q;
   assign fall      = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
   assign in_range  = int'(acc_idx) < reg_len(acc_cmd, TIME_BYTES);
   assign wr_en     = (st == LK_WR) && fall && (cnt == 4'd8) && in_range
                      && !start_det && !stop_det;
   assign wr_data   = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= LK_IDLE;
         sda_oe  <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         tx      <= '1;
         rw      <= 1'b0;
         nack    <= 1'b0;
         acc_cmd <= '0;
         acc_idx <= '0;
      end else if (start_det) begin
         st      <= LK_ADDR;
         sda_oe  <= 1'b0;
         cnt     <= '0;
         acc_idx <= '0;
      end else if (stop_det) begin
         st     <= LK_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (st)
            LK_ADDR: begin
               if (rise) begin
                  sh  <= {sh[6:0], sda};
                  cnt <= cnt + 4'd1;
               end else if (fall && cnt == 4'd8) begin
                  cnt <= '0;
                  if (sh[7:4] == DEV_CODE) begin
                     sda_oe  <= 1'b1;
                     acc_cmd <= sh[3:1];
                     rw      <= sh[0];
                     st      <= LK_AACK;
                  end else begin
                     st <= LK_IDLE;
                  end
               end
            end
            LK_AACK: if (fall) begin
               cnt <= '0;
               if (rw) begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[0];
                  st     <= LK_RD;
               end else begin
                  sda_oe <= 1'b0;
                  st     <= LK_WR;
               end
            end
            LK_WR: begin
               if (rise) begin
                  sh  <= {sda, sh[7:1]};
                  cnt <= cnt + 4'd1;
               end else if (fall && cnt == 4'd8) begin
                  cnt <= '0;
                  st  <= LK_WACK;
                  if (in_range) begin
                     sda_oe  <= 1'b1;
                     acc_idx <= (acc_idx == '1) ? acc_idx : acc_idx + 1'b1;
                  end
               end
            end
            LK_WACK: if (fall) begin
               sda_oe <= 1'b0;
               st     <= LK_WR;
            end
            LK_RD: if (fall) begin
               if (cnt == 4'd7) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  st     <= LK_RACK;
               end else begin
                  tx     <= {1'b1, tx[7:1]};
                  sda_oe <= ~tx[1];
                  cnt    <= cnt + 4'd1;
               end
            end
            LK_RACK: begin
               if (rise) begin
                  nack    <= sda;
                  acc_idx <= (acc_idx == '1) ? acc_idx : acc_idx + 1'b1;
               end else if (fall) begin
                  if (nack) begin
                     st <= LK_IDLE;
                  end else begin
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[0];
                     st     <= LK_RD;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtc_i2c_regs.sv
module rtc_i2c_regs
   import rtc_i2c_pkg::*;
#(
   parameter int  TIME_BYTES = 7,
   localparam int IDX_W      = $clog2(TIME_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    batt_low_i,
   input  logic                    wr_en,
   input  logic [2:0]              cmd,
   input  logic [IDX_W-1:0]        idx,
   input  logic [7:0]              wr_data,
   output logic [7:0]              rd_data,
   output logic [8*TIME_BYTES-1:0] time_o,
   output logic                    poc,
   output logic                    hour24_o,
   output logic                    test_mode_o
);
   logic [7:0] tb [TIME_BYTES];
   logic       bld;
   logic       clr;

   assign clr = wr_en && (cmd == CMD_STAT1) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poc         <= 1'b1;
         bld         <= 1'b0;
         hour24_o    <= 1'b0;
         test_mode_o <= 1'b0;
         for (int i = 0; i < TIME_BYTES; i++) tb[i] <= '0;
      end else begin
         if (clr)             bld <= 1'b0;
         else if (batt_low_i) bld <= 1'b1;
         if (clr) begin
            poc <= 1'b0;
            for (int i = 0; i < TIME_BYTES; i++) tb[i] <= '0;
         end
         if (wr_en) begin
            case (cmd)
               CMD_STAT1: hour24_o    <= wr_data[1];
               CMD_STAT2: test_mode_o <= wr_data[7];
               CMD_TIME:  tb[idx]     <= wr_data & time_mask(int'(idx));
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = 8'hFF;
      if (int'(idx) < reg_len(cmd, TIME_BYTES)) begin
         case (cmd)
            CMD_STAT1: rd_data = {poc, bld, 4'b0000, hour24_o, 1'b0};
            CMD_STAT2: rd_data = {test_mode_o, 7'b0};
            CMD_TIME:  rd_data = tb[idx];
            default:   rd_data = 8'hFF;
         endcase
      end
   end

   for (genvar k = 0; k < TIME_BYTES; k++) begin : g_pack
      assign time_o[8*k +: 8] = tb[k];
   end
endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target #(
   parameter logic [3:0] DEV_CODE    = 4'b0110,
   parameter int         TIME_BYTES  = 7,
   parameter int         SYNC_STAGES = 2,
   localparam int        IDX_W       = $clog2(TIME_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_o,
   output logic                    sda_oe,
   input  logic                    batt_low_i,
   output logic [8*TIME_BYTES-1:0] time_o,
   output logic                    hour24_o,
   output logic                    test_mode_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TIME_BYTES < 5 || TIME_BYTES > 8) begin : g_bad_tb
      $error("TIME_BYTES must be within 5..8");
   end

   logic             scl_s, sda_s;
   logic [7:0]       rd_data, wr_data;
   logic             wr_en, start_det, stop_det, poc;
   logic [2:0]       acc_cmd;
   logic [IDX_W-1:0] acc_idx;

   assign sda_o = 1'b0;

   rtc_i2c_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
   );

   rtc_i2c_link #(.DEV_CODE(DEV_CODE), .TIME_BYTES(TIME_BYTES)) u_link (
      .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
      .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_data(wr_data),
      .acc_cmd(acc_cmd), .acc_idx(acc_idx),
      .start_det(start_det), .stop_det(stop_det)
   );

   rtc_i2c_regs #(.TIME_BYTES(TIME_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .batt_low_i(batt_low_i),
      .wr_en(wr_en), .cmd(acc_cmd), .idx(acc_idx), .wr_data(wr_data),
      .rd_data(rd_data), .time_o(time_o), .poc(poc),
      .hour24_o(hour24_o), .test_mode_o(test_mode_o)
   );
endmodule

// File: rtl/rtc_i2c_target_chk.sv
module rtc_i2c_target_chk #(
   parameter int TIME_BYTES = 7
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    scl_s,
   input logic                    start_det,
   input logic                    stop_det,
   input logic                    sda_oe,
   input logic                    wr_en,
   input logic [2:0]              wr_cmd,
   input logic [7:0]              wr_data,
   input logic                    poc,
   input logic [8*TIME_BYTES-1:0] time_o
);
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R11

   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R3

   AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> sda_oe); // R6

   AST_CLEAR_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cmd == 3'd0 && wr_data[0]) |=> (time_o == '0)); // R9

   AST_POC_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(poc) |-> $past(wr_en && wr_cmd == 3'd0 && wr_data[0])); // R9

   AST_FIELD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (time_o[39:38] == 2'b00) && (time_o[31:27] == 5'b00000)); // R5
endmodule

bind rtc_i2c_target rtc_i2c_target_chk #(.TIME_BYTES(TIME_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en), .wr_cmd(acc_cmd),
   .wr_data(wr_data), .poc(poc), .time_o(time_o)
);

// File: tb/sim_rtc_i2c_target.sv
module sim_rtc_i2c_target;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        batt_low = 1'b0;
   logic        sda_o, sda_oe, hour24, test_mode;
   logic [55:0] time_o;
   wire         sda_line = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_time [7];
   logic       m_poc, m_bld, m_h24, m_test;
   logic [7:0] wbuf [10];
   logic       wack [10];
   logic [7:0] rbuf [10];
   logic       addr_ack;

   always #5 clk = ~clk;

   rtc_i2c_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe), .batt_low_i(batt_low),
      .time_o(time_o), .hour24_o(hour24), .test_mode_o(test_mode)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fmask(input int i);
      if (i == 3)      fmask = 8'h07;
      else if (i == 4) fmask = 8'h3F;
      else             fmask = 8'hFF;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [2:0] cmd, input int i);
      exp_rd = 8'hFF;
      if (cmd == 3'd0 && i == 0)      exp_rd = {m_poc, m_bld, 4'b0, m_h24, 1'b0};
      else if (cmd == 3'd1 && i == 0) exp_rd = {m_test, 7'b0};
      else if (cmd == 3'd2 && i < 7)  exp_rd = m_time[i];
   endfunction

   function automatic logic [55:0] exp_time();
      for (int k = 0; k < 7; k++) exp_time[8*k +: 8] = m_time[k];
   endfunction

   function automatic void model_wr(input logic [2:0] cmd, input int i, input logic [7:0] d);
      if (cmd == 3'd0 && i == 0) begin
         m_h24 = d[1];
         if (d[0]) begin
            m_poc = 1'b0; m_bld = 1'b0;
            for (int k = 0; k < 7; k++) m_time[k] = 8'h00;
         end
      end else if (cmd == 3'd1 && i == 0) begin
         m_test = d[7];
      end else if (cmd == 3'd2 && i < 7) begin
         m_time[i] = d & fmask(i);
      end
   endfunction

   function automatic int cmd_len(input logic [2:0] cmd);
      cmd_len = (cmd == 3'd2) ? 7 : ((cmd < 3'd2) ? 1 : 0);
   endfunction

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; scl = 1'b0; wq();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic byte_msb(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      ack = ~a;
   endtask

   task automatic byte_lsb(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 0; i < 8; i++) bit_out(b[i]);
      bit_in(a);
      ack = ~a;
   endtask

   task automatic byte_in(output logic [7:0] b, input logic mack);
      for (int i = 0; i < 8; i++) bit_in(b[i]);
      bit_out(~mack);
   endtask

   task automatic do_write(input logic [2:0] cmd, input int n);
      bus_start();
      byte_msb({4'b0110, cmd, 1'b0}, addr_ack);
      for (int i = 0; i < n; i++) begin
         byte_lsb(wbuf[i], wack[i]);
         if (wack[i]) model_wr(cmd, i, wbuf[i]);
      end
      bus_stop();
   endtask

   task automatic do_read(input logic [2:0] cmd, input int n, input logic stop);
      bus_start();
      byte_msb({4'b0110, cmd, 1'b1}, addr_ack);
      for (int i = 0; i < n; i++) byte_in(rbuf[i], i != n - 1);
      if (stop) bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic a, b;
      seed = $urandom(32'd4242);
      m_poc = 1'b1; m_bld = 1'b0; m_h24 = 1'b0; m_test = 1'b0;
      for (int k = 0; k < 7; k++) m_time[k] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R12 reset state
      check("R12 sda_oe", {63'd0, sda_oe}, 64'd0);
      check("R12 time_o", {8'd0, time_o}, 64'd0);
      check("R12 hour24/test", {62'd0, hour24, test_mode}, 64'd0);
      // R8 status1 after reset shows power-on flag
      do_read(3'd0, 1, 1'b1);
      check("R1 ack stat1 read", {63'd0, addr_ack}, 64'd1);
      check("R8 stat1 reset 0x80", {56'd0, rbuf[0]}, 64'h80);
      do_read(3'd1, 1, 1'b1);
      check("R10 stat2 reset", {56'd0, rbuf[0]}, 64'h00);

      // R1 wrong device code: no ACK, silent on following byte
      bus_start();
      byte_msb({4'b0101, 3'd2, 1'b0}, a);
      check("R1 foreign addr nack", {63'd0, a}, 64'd0);
      byte_lsb(8'h00, b);
      check("R1 silent after nack", {63'd0, b}, 64'd0);
      bus_stop();
      check("R1 time untouched", {8'd0, time_o}, 64'd0);

      // R4 R5 directed burst of all-ones hits masks
      for (int i = 0; i < 7; i++) wbuf[i] = 8'hFF;
      do_write(3'd2, 7);
      check("R5 masked time_o", {8'd0, time_o}, {8'd0, exp_time()});
      check("R5 hour byte", {56'd0, time_o[39:32]}, 64'h3F);
      check("R5 weekday byte", {56'd0, time_o[31:24]}, 64'h07);

      // R3 R4 asymmetric pattern shows LSB-first order and byte order
      wbuf[0] = 8'h25; wbuf[1] = 8'h12; wbuf[2] = 8'h31; wbuf[3] = 8'h06;
      wbuf[4] = 8'h23; wbuf[5] = 8'h59; wbuf[6] = 8'h48; wbuf[7] = 8'hAA;
      do_write(3'd2, 8);
      check("R4 acks first seven", {57'd0, wack[0], wack[1], wack[2], wack[3], wack[4], wack[5], wack[6]}, 64'h7F);
      check("R6 eighth byte nack", {63'd0, wack[7]}, 64'd0);
      check("R3 R4 time_o layout", {8'd0, time_o}, 64'h0048_5923_0631_1225);
      do_read(3'd2, 9, 1'b1);
      for (int i = 0; i < 7; i++) check("R3 R4 read burst", {56'd0, rbuf[i]}, {56'd0, exp_rd(3'd2, i)});
      check("R6 read past end", {48'd0, rbuf[7], rbuf[8]}, 64'hFFFF);
      check("R11 released after nack", {63'd0, sda_oe}, 64'd0);

      // R7 repeated START restarts the index
      do_read(3'd2, 3, 1'b0);
      do_read(3'd2, 1, 1'b1);
      check("R7 index restarts", {56'd0, rbuf[0]}, 64'h25);

      // R2 unimplemented command
      wbuf[0] = 8'h5A;
      do_write(3'd5, 1);
      check("R2 addr ack cmd5", {63'd0, addr_ack}, 64'd1);
      check("R2 data nack cmd5", {63'd0, wack[0]}, 64'd0);
      do_read(3'd7, 2, 1'b1);
      check("R2 cmd7 reads FF", {48'd0, rbuf[0], rbuf[1]}, 64'hFFFF);

      // R10 test flag set and clear
      wbuf[0] = 8'hFF;
      do_write(3'd1, 1);
      check("R10 test set", {63'd0, test_mode}, 64'd1);
      do_read(3'd1, 1, 1'b1);
      check("R10 stat2 read", {56'd0, rbuf[0]}, 64'h80);
      wbuf[0] = 8'h00;
      do_write(3'd1, 1);
      check("R10 test cleared", {63'd0, test_mode}, 64'd0);

      // R8 24h bit and battery flag
      wbuf[0] = 8'h02;
      do_write(3'd0, 1);
      check("R8 hour24 set", {63'd0, hour24}, 64'd1);
      check("R9 time kept without bit0", {8'd0, time_o}, {8'd0, exp_time()});
      @(negedge clk); batt_low = 1'b1; repeat (2) @(negedge clk); batt_low = 1'b0;
      m_bld = 1'b1;
      do_read(3'd0, 1, 1'b1);
      check("R8 stat1 flags", {56'd0, rbuf[0]}, 64'hC2);

      // R9 reset command
      wbuf[0] = 8'h03;
      do_write(3'd0, 1);
      check("R9 time cleared", {8'd0, time_o}, 64'd0);
      do_read(3'd0, 1, 1'b1);
      check("R9 flags cleared bit0 reads 0", {56'd0, rbuf[0]}, 64'h02);

      // R4 R6 random bursts
      for (int it = 0; it < 12; it++) begin
         int n;
         n = 1 + int'($urandom % 9);
         for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
         do_write(3'd2, n);
         for (int i = 0; i < n; i++)
            check("R6 random ack", {63'd0, wack[i]}, {63'd0, (i < 7)});
         check("R4 random time_o", {8'd0, time_o}, {8'd0, exp_time()});
         n = 1 + int'($urandom % 9);
         do_read(3'd2, n, 1'b1);
         for (int i = 0; i < n; i++)
            check("R4 random read", {56'd0, rbuf[i]}, {56'd0, exp_rd(3'd2, i)});
      end
      check("R2 len model", 64'(cmd_len(3'd2)), 64'd7);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule